// File: doc/BRIEF.md
# Equalizer Channel Control Selector

This block sits beside a four-lane line equalizer. It works out, for every lane, the 3-bit boost code that sets how much equalization the analog stage applies. It also decides whether the lane's data path is active or in standby. Boost and enable each have their own source select.

Boost comes from one of two places:
- When the force-external pin is high, every lane takes the one code on the shared boost pins.
- When it is low, each lane takes its own field from the configuration bytes.

Enable also comes from one of two places:
- When the register-control bit is clear, each lane follows its own enable pin.
- When the bit is set, each lane follows an enable bit in the configuration bytes. That bit has the opposite polarity to the pin.

The block publishes the effective settings as read-back status bytes, in the same packing as the configuration bytes. It also passes a shared 2-bit drive-level code through to the output drivers. Standby only gates the lane's data path; the management port and signal detection stay outside this block and keep running.

All pins are asynchronous to the clock. Each pin passes through a two-flop synchronizer, and every output is registered.

Top module: `eq_ctl_select`

## Requirements
- R1: While the synchronized force-external pin is 1, all four lane boost outputs equal the synchronized shared boost pin code. Configuration boost fields have no effect.
- R2: While the force-external pin is 0, each lane uses its own configuration field:
  - Byte k of `cfg_regs` (bits 8k+7..8k) serves lanes 2k and 2k+1.
  - Lane 2k takes its boost from bits 2:0 of the byte and lane 2k+1 from bits 6:4.
  - Boost codes run from 000 (weakest) to 111 (strongest).
- R3: While `reg_ctl_sel` is 0, a lane is active (`lane_active` bit 1) exactly when its synchronized enable pin is 1.
- R4: While `reg_ctl_sel` is 1:
  - Lane 2k is active when bit 3 of byte k is 0, and lane 2k+1 when bit 7 is 0. A 1 in that bit means standby.
  - The enable pins have no effect.
- R5: The two selections are independent. The force-external pin never changes `lane_active`, and `reg_ctl_sel` never changes `lane_boost`.
- R6: `stat_regs` uses the same packing as `cfg_regs`:
  - Each lane nibble holds the effective boost in its low 3 bits.
  - The top bit of the nibble is 1 when the lane is in standby.
  - The status updates in the same cycle as the lane outputs.
- R7: During and right after reset, every lane shows boost 100 and active. Each status byte reads 0x44 and `drv_level` is 10. The synchronizers start at the unconnected-pin levels: force-external 1, boost pins 100, enable pins 1.
- R8: A pin change reaches the outputs at the third rising edge after it is applied; after two edges the old value still shows. A change of `reg_ctl_sel` or `cfg_regs` shows after one edge.
- R9: `drv_level` equals bits 3:2 of `lvl_reg`, one clock edge later, and is common to all lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| force_ext_pin | input | 1 | Force-external boost pin (asynchronous) |
| boost_pin | input | 3 | Shared boost code pins (asynchronous) |
| en_pin | input | 4 | Per-lane enable pins, 1 = active (asynchronous) |
| reg_ctl_sel | input | 1 | 1 = enables come from configuration bytes |
| cfg_regs | input | 16 | Two configuration bytes, lane nibbles {standby, boost} |
| lvl_reg | input | 8 | Drive-level byte, bits 3:2 used |
| lane_boost | output | 12 | Per-lane boost codes, lane n at bits 3n+2..3n |
| lane_active | output | 4 | Per-lane active flags |
| stat_regs | output | 16 | Read-back status bytes, same packing as cfg_regs |
| drv_level | output | 2 | Shared driver level code |

## Verification
The bench targets the inverted enable polarity. A design that copied the register bit straight through would put a lane marked active into standby.

It checks that the enable pins are ignored in register mode and that each source select leaves the other path alone. Coupling either select to the wrong path would show up as a lane flag or boost code moving when only the other select changed.

It samples the pin path two and three edges after a change to pin down the synchronizer depth; an off-by-one stage count shows the new value early or late. It also checks that status nibbles carry the right lane in the right half-byte and that the reset values match the unconnected-pin defaults.

// File: rtl/eq_ctl_pkg.sv
package eq_ctl_pkg;
  localparam int BOOST_W = 3;
  localparam int NIB_W   = BOOST_W + 1;
  localparam logic [BOOST_W-1:0] BOOST_DEF = 3'b100;
  localparam logic [1:0] LVL_DEF = 2'b10;

  typedef struct packed {
    logic               stby;
    logic [BOOST_W-1:0] boost;
  } lane_nib_t;
endpackage

// File: rtl/eq_sync.sv
module eq_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/eq_lane_sel.sv
module eq_lane_sel
  import eq_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               force_s,
  input  logic [BOOST_W-1:0] pin_boost_s,
  input  logic               en_pin_s,
  input  logic               ctl_sel,
  input  lane_nib_t          reg_nib,
  output logic [BOOST_W-1:0] boost_nxt,
  output logic               active_nxt,
  output logic [BOOST_W-1:0] boost_q,
  output logic               active_q
);
  // boost source: shared pins or own field
  always_comb begin
    if (force_s) boost_nxt = pin_boost_s;
    else         boost_nxt = reg_nib.boost;
  end

  // enable source: pin is active-high, register bit is active-low
  always_comb begin
    if (ctl_sel) active_nxt = ~reg_nib.stby;
    else         active_nxt = en_pin_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      boost_q  <= BOOST_DEF;
      active_q <= 1'b1;
    end else begin
      boost_q  <= boost_nxt;
      active_q <= active_nxt;
    end
  end
endmodule

// File: rtl/eq_status_pack.sv
module eq_status_pack
  import eq_ctl_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BOOST_W*NUM_CH-1:0] boost_nxt,
  input  logic [NUM_CH-1:0]         active_nxt,
  output logic [NIB_W*NUM_CH-1:0]   stat
);
  localparam lane_nib_t NIB_RST = '{stby: 1'b0, boost: BOOST_DEF};

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_nib
      always_ff @(posedge clk) begin
        if (rst) stat[g*NIB_W +: NIB_W] <= NIB_RST;
        else     stat[g*NIB_W +: NIB_W] <= {~active_nxt[g], boost_nxt[g*BOOST_W +: BOOST_W]};
      end
    end
  endgenerate
endmodule

// File: rtl/eq_ctl_select.sv
module eq_ctl_select
  import eq_ctl_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int LVL_LSB     = 2,
  parameter int LVL_W       = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      force_ext_pin,
  input  logic [BOOST_W-1:0]        boost_pin,
  input  logic [NUM_CH-1:0]         en_pin,
  input  logic                      reg_ctl_sel,
  input  logic [NIB_W*NUM_CH-1:0]   cfg_regs,
  input  logic [7:0]                lvl_reg,
  output logic [BOOST_W*NUM_CH-1:0] lane_boost,
  output logic [NUM_CH-1:0]         lane_active,
  output logic [NIB_W*NUM_CH-1:0]   stat_regs,
  output logic [LVL_W-1:0]          drv_level
);
  localparam int PIN_W = 1 + BOOST_W + NUM_CH;
  localparam logic [PIN_W-1:0] PIN_RST = {1'b1, BOOST_DEF, {NUM_CH{1'b1}}};

  logic [PIN_W-1:0]          pins_s;
  logic                      force_s;
  logic [BOOST_W-1:0]        pin_boost_s;
  logic [NUM_CH-1:0]         en_s;
  logic [BOOST_W*NUM_CH-1:0] boost_nxt;
  logic [NUM_CH-1:0]         active_nxt;

  eq_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({force_ext_pin, boost_pin, en_pin}),
    .q   (pins_s)
  );

  assign {force_s, pin_boost_s, en_s} = pins_s;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_lane
      eq_lane_sel u_lane (
        .clk         (clk),
        .rst         (rst),
        .force_s     (force_s),
        .pin_boost_s (pin_boost_s),
        .en_pin_s    (en_s[g]),
        .ctl_sel     (reg_ctl_sel),
        .reg_nib     (lane_nib_t'(cfg_regs[g*NIB_W +: NIB_W])),
        .boost_nxt   (boost_nxt[g*BOOST_W +: BOOST_W]),
        .active_nxt  (active_nxt[g]),
        .boost_q     (lane_boost[g*BOOST_W +: BOOST_W]),
        .active_q    (lane_active[g])
      );
    end
  endgenerate

  eq_status_pack #(.NUM_CH(NUM_CH)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .boost_nxt  (boost_nxt),
    .active_nxt (active_nxt),
    .stat       (stat_regs)
  );

  always_ff @(posedge clk) begin
    if (rst) drv_level <= LVL_DEF;
    else     drv_level <= lvl_reg[LVL_LSB +: LVL_W];
  end

  // ---------------- assertions ----------------
  logic [1:0] run_cnt;
  logic       ready;
  always_ff @(posedge clk) begin
    if (rst)                run_cnt <= '0;
    else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
  end
  assign ready = (run_cnt == 2'd3);

  generate
    for (g = 0; g < NUM_CH; g++) begin : g_chk
      // R6: status nibble tracks the lane outputs
      a_r6_status_mirror: assert property (@(posedge clk) disable iff (rst)
        ready |-> stat_regs[g*NIB_W +: NIB_W] ==
                  {~lane_active[g], lane_boost[g*BOOST_W +: BOOST_W]});

      // R1: forced mode gives every lane the shared pin code
      a_r1_shared_code: assert property (@(posedge clk) disable iff (rst)
        (ready && force_s) |=> lane_boost[g*BOOST_W +: BOOST_W] == $past(pin_boost_s));

      // R4: register mode with steady config keeps active flags steady
      a_r4_pins_ignored: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(reg_ctl_sel) && $past(reg_ctl_sel, 2) &&
         $past(cfg_regs) == $past(cfg_regs, 2)) |-> $stable(lane_active[g]));
    end
  endgenerate

  // R9: drive level follows its byte one edge later
  a_r9_level_pass: assert property (@(posedge clk) disable iff (rst)
    ready |-> drv_level == $past(lvl_reg[LVL_LSB +: LVL_W]));
endmodule

// File: tb/eq_ctl_select_test.sv
module eq_ctl_select_test;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        force_ext_pin = 1'b1;
  logic [2:0]  boost_pin = 3'b100;
  logic [3:0]  en_pin = 4'b1111;
  logic        reg_ctl_sel = 1'b0;
  logic [15:0] cfg_regs = 16'h4444;
  logic [7:0]  lvl_reg = 8'h78;
  logic [11:0] lane_boost;
  logic [3:0]  lane_active;
  logic [15:0] stat_regs;
  logic [1:0]  drv_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  eq_ctl_select uut (
    .clk(clk), .rst(rst), .force_ext_pin(force_ext_pin), .boost_pin(boost_pin),
    .en_pin(en_pin), .reg_ctl_sel(reg_ctl_sel), .cfg_regs(cfg_regs), .lvl_reg(lvl_reg),
    .lane_boost(lane_boost), .lane_active(lane_active), .stat_regs(stat_regs),
    .drv_level(drv_level)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] m_boost(input int ch);
    return force_ext_pin ? boost_pin : cfg_regs[ch*4 +: 3];
  endfunction

  function automatic logic m_active(input int ch);
    return reg_ctl_sel ? ~cfg_regs[ch*4 + 3] : en_pin[ch];
  endfunction

  // compare every output against the model of the present stimulus
  task automatic check_all(input string req);
    for (int ch = 0; ch < NCH; ch++) begin
      chk({req, " boost"}, lane_boost[ch*3 +: 3], m_boost(ch));
      chk({req, " active"}, lane_active[ch], m_active(ch));
      chk({req, " R6 status"}, stat_regs[ch*4 +: 4], {~m_active(ch), m_boost(ch)});
    end
    chk({req, " R9 level"}, drv_level, lvl_reg[3:2]);
  endtask

  task automatic t_reset;
    chk("R7 boost", lane_boost, 12'o4444);
    chk("R7 active", lane_active, 4'hF);
    chk("R7 status", stat_regs, 16'h4444);
    chk("R7 level", drv_level, 2'b10);
  endtask

  task automatic t_pin_boost;
    cfg_regs = 16'h1234;
    boost_pin = 3'b011;
    settle(2);
    chk("R8 pin not yet", lane_boost[2:0], 3'b100);
    settle(1);
    check_all("R1");
    chk("R8 pin at third edge", lane_boost, 12'o3333);
  endtask

  task automatic t_reg_boost;
    force_ext_pin = 1'b0;
    cfg_regs = 16'hF152;
    settle(3);
    check_all("R2");
    chk("R2 packed", lane_boost, {3'd7, 3'd1, 3'd5, 3'd2});
    cfg_regs = 16'h0763;
    settle(1);
    chk("R8 reg one edge", lane_boost, {3'd0, 3'd7, 3'd6, 3'd3});
  endtask

  task automatic t_pin_enable;
    cfg_regs = 16'h8888;
    en_pin = 4'b1010;
    settle(3);
    check_all("R3");
    chk("R3 flags", lane_active, 4'b1010);
  endtask

  task automatic t_reg_enable;
    cfg_regs = 16'hF152;
    reg_ctl_sel = 1'b1;
    settle(1);
    check_all("R4");
    chk("R4 inverted", lane_active, 4'b0111);
    en_pin = 4'b0000;
    settle(4);
    chk("R4 pins ignored", lane_active, 4'b0111);
    en_pin = 4'b1111;
    settle(4);
    chk("R4 pins ignored high", lane_active, 4'b0111);
  endtask

  task automatic t_indep;
    force_ext_pin = 1'b1;
    boost_pin = 3'b110;
    settle(4);
    chk("R5 force leaves enable", lane_active, 4'b0111);
    check_all("R5");
    reg_ctl_sel = 1'b0;
    en_pin = 4'b0101;
    settle(4);
    chk("R5 ctl leaves boost", lane_boost, 12'o6666);
    check_all("R5 b");
  endtask

  task automatic t_level;
    lvl_reg = 8'b1111_0011;
    settle(1);
    chk("R9 level 00", drv_level, 2'b00);
    lvl_reg = 8'b0000_1100;
    settle(1);
    chk("R9 level 11", drv_level, 2'b11);
    lvl_reg = 8'b0000_0100;
    settle(1);
    chk("R9 level 01", drv_level, 2'b01);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    settle(1);
    t_reset();
    t_pin_boost();
    t_reg_boost();
    t_pin_enable();
    t_reg_enable();
    t_indep();
    t_level();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule